// File: doc/BRIEF.md
# Staggered Doppler Frame Processor

This block gathers one frame of slow-time radar data and converts it into Doppler spectra. A stream of complex range-bin samples is written into an internal frame buffer. One frame holds 32 chirps of 64 range bins each. Once the frame is complete, the block processes each range bin in turn. It splits that bin's 32 slow-time samples into two 16-chirp halves, one for each interval of a staggered pulse-repetition scheme. It tapers each half with a Hamming window and transforms it with a 16-point DFT.

The two 16-bin spectra are concatenated into one 32-bin row. Rows leave in range order over a valid/ready stream. The DFT runs on a single complex multiply-accumulate unit, one product per clock, so the block trades latency for area. No new frame is accepted while a frame is being processed or emitted.

Both streams follow valid/ready rules. A transfer happens on a rising edge where valid and ready are both high. While `out_valid` is high and `out_ready` is low, the output word and its row marker stay frozen. The input side never needs to hold `in_data` stable, because a sample is only taken on a transfer. Back-pressure on the input appears as `in_ready` staying low for the whole processing period.

Top module: `dopp_frame_proc`

## Requirements
- R1: While reset is held, `in_ready`, `out_valid` and `frame_done` are low. `in_ready` is high by the second clock after reset release.
- R2: The block accepts exactly 2048 samples per frame. The sample for chirp c, range bin r is the (c*64+r)-th transfer. `in_ready` is low from the cycle after the 2048th transfer until the frame has been fully emitted. `in_ready` and `out_valid` are never high together.
- R3: Each sample component x (signed 16-bit) at slow-time position n (0..15 within its half) is windowed as (x*w[n] + 2^14) >>> 15. The coefficient is w[n] = round(32767*(0.54 - 0.46*cos(2*pi*n/15))), and the same taper applies to both halves.
- R4: For bin k, with C(m) = round(32767*cos(2*pi*m/16)), S(m) = round(32767*sin(2*pi*m/16)) and m = n*k mod 16, the block computes two exact sums. The real sum is the sum of xr*C + xi*S. The imaginary sum is the sum of xi*C - xr*S. Each output component is (sum + 2^18) >>> 19, which is the DFT scaled by 1/16.
- R5: Packed bins 0..15 of a row depend only on chirps 0..15, and bins 16..31 depend only on chirps 16..31.
- R6: Output is range-major: 64 rows of 32 words, with row r covering range bin r. Bin b of row r is the (r*32+b)-th output transfer. Every word, input or output, is {imag[31:16], real[15:0]}.
- R7: `out_last` is high exactly on the 32nd word of each row.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` and `out_last` do not change.
- R9: `frame_done` is a single-cycle pulse in the cycle right after the 2048th output transfer, and it appears at no other time.
- R10: A frame that starts right after `frame_done` gives results that depend only on its own samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (100 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block is collecting a frame |
| in_data | input | 32 | Input sample {imag, real} |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Doppler bin {imag, real} |
| out_last | output | 1 | Final word of a 32-bin row |
| frame_done | output | 1 | Pulse after the final word of a frame |

## Verification
The checker counts transfers on both streams from reset, so its properties assume that traffic starts only after reset and that each frame is exactly 2048 input samples. The bench sends whole frames only, drives everything on the falling edge, and idles the input once a frame is complete. `out_ready` is treated as arbitrary, so the bench toggles it in a fixed pattern during one frame to exercise the hold rule. Expected spectra come from a floating-point derivation of the window and twiddle tables, followed by exact integer arithmetic.

// File: rtl/dopp_pkg.sv
package dopp_pkg;

  localparam int SUB_LEN = 16;
  localparam int CPLX_W  = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCUM,
    ST_LOAD,
    ST_MAC,
    ST_DRAIN,
    ST_OUTPUT
  } dstate_t;

  // Symmetric 16-tap Hamming taper, Q15
  function automatic logic signed [15:0] taper_q15(input logic [3:0] n);
    logic [3:0] f;
    f = n[3] ? (4'd15 - n) : n;
    case (f[2:0])
      3'd0:    taper_q15 = 16'sd2621;
      3'd1:    taper_q15 = 16'sd3924;
      3'd2:    taper_q15 = 16'sd7608;
      3'd3:    taper_q15 = 16'sd13036;
      3'd4:    taper_q15 = 16'sd19270;
      3'd5:    taper_q15 = 16'sd25231;
      3'd6:    taper_q15 = 16'sd29888;
      default: taper_q15 = 16'sd32438;
    endcase
  endfunction

  // cos(2*pi*m/16) in Q15
  function automatic logic signed [15:0] cos16_q15(input logic [3:0] m);
    case (m)
      4'd0:    cos16_q15 = 16'sd32767;
      4'd1:    cos16_q15 = 16'sd30273;
      4'd2:    cos16_q15 = 16'sd23170;
      4'd3:    cos16_q15 = 16'sd12539;
      4'd4:    cos16_q15 = 16'sd0;
      4'd5:    cos16_q15 = -16'sd12539;
      4'd6:    cos16_q15 = -16'sd23170;
      4'd7:    cos16_q15 = -16'sd30273;
      4'd8:    cos16_q15 = -16'sd32767;
      4'd9:    cos16_q15 = -16'sd30273;
      4'd10:   cos16_q15 = -16'sd23170;
      4'd11:   cos16_q15 = -16'sd12539;
      4'd12:   cos16_q15 = 16'sd0;
      4'd13:   cos16_q15 = 16'sd12539;
      4'd14:   cos16_q15 = 16'sd23170;
      default: cos16_q15 = 16'sd30273;
    endcase
  endfunction

endpackage

// File: rtl/dopp_frame_buf.sv
module dopp_frame_buf #(
  parameter int DEPTH = 2048,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/dopp_window.sv
module dopp_window
  import dopp_pkg::*;
(
  input  logic [CPLX_W-1:0] sample,
  input  logic [3:0]        tap,
  output logic [CPLX_W-1:0] tapered
);

  logic signed [15:0] coef;
  logic signed [31:0] prod_re, prod_im;
  logic signed [31:0] rnd_re, rnd_im;
  logic               unused_win;

  always_comb begin
    coef    = taper_q15(tap);
    prod_re = $signed(sample[15:0]) * coef;
    prod_im = $signed(sample[31:16]) * coef;
    rnd_re  = prod_re + 32'sd16384;
    rnd_im  = prod_im + 32'sd16384;
    tapered = {rnd_im[30:15], rnd_re[30:15]};
  end

  assign unused_win = ^{rnd_re[31], rnd_re[14:0], rnd_im[31], rnd_im[14:0]};

endmodule

// File: rtl/dopp_mac.sv
module dopp_mac
  import dopp_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    first,
  input  logic [CPLX_W-1:0]       xw,
  input  logic [3:0]              tw_idx,
  output logic signed [ACC_W-1:0] acc_re,
  output logic signed [ACC_W-1:0] acc_im
);

  logic signed [15:0] c, s, xr, xi;
  logic signed [31:0] p_rc, p_is, p_ic, p_rs;
  logic signed [ACC_W-1:0] term_re, term_im;

  always_comb begin
    c    = cos16_q15(tw_idx);
    s    = cos16_q15(tw_idx + 4'd12);
    xr   = xw[15:0];
    xi   = xw[31:16];
    p_rc = xr * c;
    p_is = xi * s;
    p_ic = xi * c;
    p_rs = xr * s;
    term_re = ACC_W'(p_rc) + ACC_W'(p_is);
    term_im = ACC_W'(p_ic) - ACC_W'(p_rs);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (en) begin
      acc_re <= (first ? '0 : acc_re) + term_re;
      acc_im <= (first ? '0 : acc_im) + term_im;
    end
  end

endmodule

// File: rtl/dopp_frame_proc.sv
module dopp_frame_proc
  import dopp_pkg::*;
#(
  parameter int CHIRPS = 32,
  parameter int RANGES = 64,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CPLX_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CPLX_W-1:0] out_data,
  output logic              out_last,
  output logic              frame_done
);

  localparam int TOTAL  = CHIRPS * RANGES;
  localparam int ADDR_W = $clog2(TOTAL);
  localparam int RB_W   = $clog2(RANGES);
  localparam int SUBS   = CHIRPS / SUB_LEN;
  localparam int SUB_W  = $clog2(SUBS);
  localparam int ROW_W  = $clog2(CHIRPS);
  localparam int SHIFT  = 19;

  dstate_t state;
  logic [ADDR_W-1:0] wr_cnt;
  logic [RB_W-1:0]   rbin;
  logic [SUB_W-1:0]  sub;
  logic [4:0]        ld_cnt;
  logic [3:0]        ld_idx, k_cnt, m_cnt, tw_idx;
  logic [ROW_W-1:0]  e_idx, row_wr;
  logic [CPLX_W-1:0] xw_q  [SUB_LEN];
  logic [CPLX_W-1:0] row_q [CHIRPS];
  logic [CPLX_W-1:0] buf_rdata, win_out, bin_word;
  logic [ADDR_W-1:0] buf_raddr;
  logic signed [ACC_W-1:0] acc_re, acc_im, rnd_re, rnd_im;
  logic fire_in, fire_out;
  logic unused_rnd;

  assign in_ready  = (state == ST_ACCUM);
  assign out_valid = (state == ST_OUTPUT);
  assign out_data  = row_q[e_idx];
  assign out_last  = (e_idx == ROW_W'(CHIRPS - 1));
  assign fire_in   = in_valid && in_ready;
  assign fire_out  = out_valid && out_ready;

  assign buf_raddr = {sub, ld_cnt[3:0], rbin};
  assign ld_idx    = ld_cnt[3:0] - 4'd1;
  assign tw_idx    = m_cnt * k_cnt;
  assign row_wr    = {sub, k_cnt};

  dopp_frame_buf #(.DEPTH(TOTAL), .W(CPLX_W)) u_buf (
    .clk   (clk),
    .we    (fire_in),
    .waddr (wr_cnt),
    .wdata (in_data),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  dopp_window u_win (
    .sample  (buf_rdata),
    .tap     (ld_idx),
    .tapered (win_out)
  );

  dopp_mac #(.ACC_W(ACC_W)) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (state == ST_MAC),
    .first  (m_cnt == 4'd0),
    .xw     (xw_q[m_cnt]),
    .tw_idx (tw_idx),
    .acc_re (acc_re),
    .acc_im (acc_im)
  );

  // Scaled, rounded bin value
  assign rnd_re   = acc_re + ACC_W'(2**(SHIFT-1));
  assign rnd_im   = acc_im + ACC_W'(2**(SHIFT-1));
  assign bin_word = {rnd_im[SHIFT+15:SHIFT], rnd_re[SHIFT+15:SHIFT]};
  assign unused_rnd = ^{rnd_re[ACC_W-1:SHIFT+16], rnd_re[SHIFT-1:0],
                        rnd_im[ACC_W-1:SHIFT+16], rnd_im[SHIFT-1:0]};

  // Windowed sub-frame staging
  always_ff @(posedge clk) begin
    if (state == ST_LOAD && ld_cnt != 5'd0) xw_q[ld_idx] <= win_out;
  end

  // Packed row storage, one register per bin
  for (genvar gi = 0; gi < CHIRPS; gi++) begin : g_row
    always_ff @(posedge clk) begin
      if (state == ST_DRAIN && row_wr == ROW_W'(gi)) row_q[gi] <= bin_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wr_cnt     <= '0;
      rbin       <= '0;
      sub        <= '0;
      ld_cnt     <= '0;
      k_cnt      <= '0;
      m_cnt      <= '0;
      e_idx      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          wr_cnt <= '0;
          state  <= ST_ACCUM;
        end
        ST_ACCUM: begin
          if (fire_in) begin
            wr_cnt <= wr_cnt + 1'b1;
            if (wr_cnt == ADDR_W'(TOTAL - 1)) begin
              state  <= ST_LOAD;
              rbin   <= '0;
              sub    <= '0;
              ld_cnt <= '0;
            end
          end
        end
        ST_LOAD: begin
          ld_cnt <= ld_cnt + 5'd1;
          if (ld_cnt == 5'(SUB_LEN)) begin
            state <= ST_MAC;
            k_cnt <= '0;
            m_cnt <= '0;
          end
        end
        ST_MAC: begin
          m_cnt <= m_cnt + 4'd1;
          if (m_cnt == 4'(SUB_LEN - 1)) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (k_cnt == 4'(SUB_LEN - 1)) begin
            k_cnt <= '0;
            if (sub == SUB_W'(SUBS - 1)) begin
              state <= ST_OUTPUT;
              e_idx <= '0;
            end else begin
              sub    <= sub + 1'b1;
              ld_cnt <= '0;
              state  <= ST_LOAD;
            end
          end else begin
            k_cnt <= k_cnt + 4'd1;
            m_cnt <= '0;
            state <= ST_MAC;
          end
        end
        ST_OUTPUT: begin
          if (fire_out) begin
            e_idx <= e_idx + 1'b1;
            if (out_last) begin
              sub    <= '0;
              ld_cnt <= '0;
              if (rbin == RB_W'(RANGES - 1)) begin
                rbin       <= '0;
                frame_done <= 1'b1;
                state      <= ST_IDLE;
              end else begin
                rbin  <= rbin + 1'b1;
                state <= ST_LOAD;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dopp_frame_proc_chk.sv
module dopp_frame_proc_chk #(
  parameter int CHIRPS = 32,
  parameter int RANGES = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_last,
  input logic        frame_done
);

  localparam int TOTAL  = CHIRPS * RANGES;
  localparam int ADDR_W = $clog2(TOTAL);
  localparam int ROW_W  = $clog2(CHIRPS);

  logic [ADDR_W-1:0] in_cnt, out_cnt;
  logic in_fire, out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (in_fire)  in_cnt  <= in_cnt + 1'b1;
      if (out_fire) out_cnt <= out_cnt + 1'b1;
    end
  end

  // R2: intake closes right after the final sample of a frame
  a_r2_intake_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_cnt == ADDR_W'(TOTAL - 1)) |=> !in_ready);

  // R2: intake and emission never overlap
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R7: row marker sits on every 32nd word
  a_r7_row_marker: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (out_cnt[ROW_W-1:0] == ROW_W'(CHIRPS - 1))));

  // R8: stalled word is held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9: done follows the final word
  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_cnt == ADDR_W'(TOTAL - 1)) |=> frame_done);

  // R9: done only after the final word
  a_r9_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(out_fire && out_last && out_cnt == ADDR_W'(TOTAL - 1)));

  // R9: single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

bind dopp_frame_proc dopp_frame_proc_chk #(.CHIRPS(CHIRPS), .RANGES(RANGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last),
  .frame_done (frame_done)
);

// File: tb/dopp_frame_proc_test.sv
module dopp_frame_proc_test;

  localparam int CLK_PERIOD = 10;
  localparam int CHIRPS = 32;
  localparam int RANGES = 64;
  localparam int TOTAL  = CHIRPS * RANGES;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_data;
  logic out_last;
  logic frame_done;

  int nchk = 0;
  int nerr = 0;

  logic [31:0] frm [TOTAL];
  logic [31:0] got [TOTAL];
  longint w_tab [16];
  longint c_tab [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dopp_frame_proc #(.CHIRPS(CHIRPS), .RANGES(RANGES)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint rnd(input real x);
    if (x >= 0.0) return longint'($rtoi(x + 0.5));
    else return -longint'($rtoi(-x + 0.5));
  endfunction

  // Expected word for range r, packed bin b (R3, R4, R5)
  function automatic logic [31:0] model(input int r, input int b);
    int s, k;
    longint xr, xi, wr, wi, ar, ai, cc, ss;
    logic [15:0] ore, oim;
    s = b / 16;
    k = b % 16;
    ar = 0;
    ai = 0;
    for (int n = 0; n < 16; n++) begin
      xr = longint'($signed(frm[(s*16+n)*RANGES + r][15:0]));
      xi = longint'($signed(frm[(s*16+n)*RANGES + r][31:16]));
      wr = (xr * w_tab[n] + 16384) >>> 15;
      wi = (xi * w_tab[n] + 16384) >>> 15;
      cc = c_tab[(n*k) % 16];
      ss = c_tab[((n*k) + 12) % 16];
      ar += wr * cc + wi * ss;
      ai += wi * cc - wr * ss;
    end
    ore = 16'((ar + 262144) >>> 19);
    oim = 16'((ai + 262144) >>> 19);
    return {oim, ore};
  endfunction

  task automatic send_frame(input bit gaps);
    int i = 0;
    int j = 0;
    while (i < TOTAL) begin
      @(negedge clk);
      j++;
      if (gaps && (j % 3 == 0)) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_data  = frm[i];
      end
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2", "in_ready after last sample", longint'(in_ready), 0);
  endtask

  task automatic collect_frame(input bit stall, input string tag);
    int idx = 0;
    int j = 0;
    bit hold = 1'b0;
    bit bad_ready = 1'b0;
    bit early_done = 1'b0;
    logic [31:0] held = '0;
    logic [31:0] exp;
    while (idx < TOTAL) begin
      @(negedge clk);
      j++;
      if (hold)
        chk(out_valid && out_data == held, "R8", "held word",
            longint'(out_data), longint'(held));
      if (in_ready) bad_ready = 1'b1;
      if (frame_done) early_done = 1'b1;
      out_ready = stall ? (j % 4 != 1) : 1'b1;
      if (out_valid) begin
        if (out_ready) begin
          exp = model(idx / CHIRPS, idx % CHIRPS);
          got[idx] = out_data;
          chk(out_data == exp, tag, "bin value", longint'(out_data), longint'(exp));
          chk(out_last == (idx % CHIRPS == CHIRPS - 1), "R7", "row marker",
              longint'(out_last), longint'(idx % CHIRPS == CHIRPS - 1));
          idx++;
          hold = 1'b0;
        end else begin
          hold = 1'b1;
          held = out_data;
        end
      end else begin
        hold = 1'b0;
      end
    end
    chk(!bad_ready, "R2", "in_ready low while busy", longint'(bad_ready), 0);
    chk(!early_done, "R9", "no early done", longint'(early_done), 0);
    @(negedge clk);
    chk(frame_done == 1'b1, "R9", "done after last word", longint'(frame_done), 1);
    @(negedge clk);
    chk(frame_done == 1'b0, "R9", "done width", longint'(frame_done), 0);
    out_ready = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", longint'(in_ready), 0);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    chk(frame_done == 1'b0, "R1", "frame_done in reset", longint'(frame_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
  endtask

  // Impulses in each half: halves must stay separate (R5)
  task automatic t_impulse;
    for (int i = 0; i < TOTAL; i++) frm[i] = '0;
    frm[2*RANGES + 7]  = {16'sd0, 16'sd16384};
    frm[20*RANGES + 9] = {-16'sd15000, 16'sd0};
    send_frame(1'b0);
    collect_frame(1'b0, "R6");
    for (int b = 0; b < 16; b++) begin
      chk(got[7*CHIRPS + 16 + b] == 32'd0, "R5", "half 1 clear of chirp 2",
          longint'(got[7*CHIRPS + 16 + b]), 0);
      chk(got[9*CHIRPS + b] == 32'd0, "R5", "half 0 clear of chirp 20",
          longint'(got[9*CHIRPS + b]), 0);
    end
    chk(got[7*CHIRPS] != 32'd0, "R4", "impulse reaches bin 0", longint'(got[7*CHIRPS]), 1);
  endtask

  // Pseudo-random full-scale data, input gaps and output stalls
  task automatic t_random;
    int unsigned seed = 32'h1234_5678;
    for (int i = 0; i < TOTAL; i++) begin
      seed = seed * 1103515245 + 12345;
      frm[i] = seed;
    end
    send_frame(1'b1);
    collect_frame(1'b1, "R3");
  endtask

  // Second frame straight after the first: constant input
  task automatic t_back_to_back;
    for (int i = 0; i < TOTAL; i++) frm[i] = {-16'sd3000, 16'sd8000};
    send_frame(1'b0);
    collect_frame(1'b0, "R10");
  endtask

  initial begin
    for (int n = 0; n < 16; n++) begin
      w_tab[n] = rnd(32767.0 * (0.54 - 0.46 * $cos(2.0 * PI * n / 15.0)));
      c_tab[n] = rnd(32767.0 * $cos(2.0 * PI * n / 16.0));
    end
    t_reset();
    t_impulse();
    t_random();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule